// File: doc/BRIEF.md
# Oversampled serial receiver with per-character error flags

This block turns an asynchronous serial line into characters. An external baud generator supplies a one-cycle sample pulse at 16, 8 or 3 times the bit rate. The receiver counts these pulses to find each bit's centre. It takes a majority vote of three samples around that centre. It then collects the start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. The finished character goes into a single holding register. Five error bits travel with it, and a priority code names the most important error.

Inputs select the frame shape and the bit order. Other inputs invert the line and route the local transmitter output back to the receiver for self-test. A request-to-send output tells the far end when the holding register can take another character. The consumer reads by pulsing the read strobe while the empty flag is low.

The controller has six states. ST_IDLE goes to ST_START on a sample pulse that sees the line low. ST_START returns to ST_IDLE when the start bit's vote is high, which marks the edge as a glitch; otherwise it goes to ST_DATA at the end of the bit. ST_DATA stays put until the last data bit, then goes to ST_PARITY if parity is on, or to ST_STOP1 if not. ST_PARITY goes to ST_STOP1. ST_STOP1 goes to ST_STOP2 when two stop bits are selected and to ST_IDLE otherwise. ST_STOP2 goes to ST_IDLE. The step into ST_IDLE from the final stop state writes the character.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, rx_empty is 1, rx_err is 0 and rx_top_err is 0. rx_empty stays 1 until a frame completes. rx_err bit 4 is framing, bit 3 parity, bit 2 break, bit 1 overrun and bit 0 noise.
- R2: With 16x oversampling, 8 data bits, no parity and one stop bit, a frame sent least-significant bit first appears unchanged on rx_data with rx_err equal to 0.
- R3: word_len 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits; rx_data bits above the word length read 0.
- R4: When msb_first is 1, the first data bit received is placed in bit (word length - 1) of rx_data.
- R5: With parity_en set, the parity bit must make the total count of ones even (parity_odd 0) or odd (parity_odd 1); a mismatch sets rx_err bit 3.
- R6: A low vote on any stop bit (the first, or the second when two_stop is set) sets rx_err bit 4.
- R7: A frame whose every bit position votes low, stop bits included, sets rx_err bit 2, and rx_data reads 0.
- R8: A frame that completes while a character is held and unread is discarded. The held character keeps its data and gains rx_err bit 1; a read then sets rx_empty.
- R9: Each bit is decided by a majority of three samples around mid-bit. If the three samples disagree anywhere in the frame, rx_err bit 0 is set.
- R10: A falling edge whose start-bit vote is high is ignored; the receiver returns to idle and no character is stored.
- R11: ovs_sel 0, 1 and 2 select 16, 8 and 3 sample pulses per bit. The samples sit at pulse indices 7-9, 3-5 and 0-2 of each bit.
- R12: With loop_en set, the receiver decodes tx_loop instead of rx_pin. With invert_in set, the selected line is inverted before decoding.
- R13: rts is 1 only while rts_en is 1 and no unread character is held.
- R14: rx_top_err gives the highest-priority set error: 1 framing, 2 parity, 3 break, 4 overrun, 5 noise, 0 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Oversampling pulse from the baud generator |
| ovs_sel | input | 2 | Samples per bit: 0=16, 1=8, 2=3 |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | Two stop bits |
| msb_first | input | 1 | Most significant data bit arrives first |
| invert_in | input | 1 | Invert the selected line |
| loop_en | input | 1 | Decode tx_loop instead of rx_pin |
| rx_pin | input | 1 | Serial input line |
| tx_loop | input | 1 | Local transmitter output, for loopback |
| rd_en | input | 1 | Read strobe; frees the holding register |
| rts_en | input | 1 | Enable for the request-to-send output |
| rx_empty | output | 1 | No unread character is held |
| rx_data | output | 8 | Held character |
| rx_err | output | 5 | Error bits of the held character |
| rx_top_err | output | 3 | Priority code of the highest set error |
| rts | output | 1 | Request to send |

## Verification
The bench tries clean frames at every word length, in both bit orders and at all three oversampling rates. These frames separate a bit-placement fault from a sample-timing fault. Frames with a corrupted parity bit, a low first or second stop bit, an all-low line, and a single flipped centre sample each aim at one error bit. The centre-sample flip also shows that the majority vote keeps the data value while still raising the noise flag. A short low pulse, a second frame sent before the first is read, and frames carrying several faults at once exercise glitch rejection, overrun retention and the priority order. Loopback and inversion are tried with the unused input held at a level that would otherwise corrupt the frame.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int DATA_W = 8;
    localparam int ERR_W  = 5;
    localparam int CNT_W  = 4;
    localparam int IDX_W  = $clog2(DATA_W);

    localparam int ERR_FRM = 4;
    localparam int ERR_PAR = 3;
    localparam int ERR_BRK = 2;
    localparam int ERR_OVR = 1;
    localparam int ERR_NSE = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
    } rx_state_t;

    function automatic logic [CNT_W-1:0] ovs_last(input logic [1:0] sel);
        case (sel)
            2'd1:    return CNT_W'(7);
            2'd2:    return CNT_W'(2);
            default: return CNT_W'(15);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] ovs_mid(input logic [1:0] sel);
        case (sel)
            2'd1:    return CNT_W'(4);
            2'd2:    return CNT_W'(1);
            default: return CNT_W'(8);
        endcase
    endfunction

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction
endpackage

// File: rtl/srx_line_in.sv
module srx_line_in #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic loop_src,
    input  logic loop_en,
    input  logic invert,
    output logic line
);
    logic raw;
    logic [SYNC_STAGES-1:0] sync_q;

    assign raw = (loop_en ? loop_src : pin) ^ invert;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    assign line = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/srx_vote.sv
module srx_vote
    import srx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic capture,
    output logic vote,
    output logic noisy
);
    logic [2:0] samp_q;
    logic [2:0] samp_now;

    assign samp_now = capture ? {samp_q[1:0], line} : samp_q;
    assign vote     = maj3(samp_now);
    assign noisy    = (|samp_now) && !(&samp_now);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       samp_q <= 3'b111;
        else if (capture) samp_q <= samp_now;
    end
endmodule

// File: rtl/srx_holding.sv
module srx_holding
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd,
    output logic              empty,
    output logic [DATA_W-1:0] data,
    output logic [ERR_W-1:0]  err,
    output logic [2:0]        top_err
);
    logic full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data   <= '0;
            err    <= '0;
        end else if (wr && (!full_q || rd)) begin
            full_q <= 1'b1;
            data   <= wr_data;
            err    <= wr_err;
        end else begin
            if (wr) err[ERR_OVR] <= 1'b1;
            if (rd) full_q <= 1'b0;
        end
    end

    assign empty = !full_q;

    always_comb begin
        top_err = 3'd0;
        for (int i = 0; i < ERR_W; i++) begin
            if (err[i]) top_err = 3'(ERR_W - i);
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic [1:0]        ovs_sel,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              msb_first,
    input  logic              invert_in,
    input  logic              loop_en,
    input  logic              rx_pin,
    input  logic              tx_loop,
    input  logic              rd_en,
    input  logic              rts_en,
    output logic              rx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic [ERR_W-1:0]  rx_err,
    output logic [2:0]        rx_top_err,
    output logic              rts
);
    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  tcnt_q, last_idx, mid_idx;
    logic [IDX_W-1:0]  bidx_q, wl_last, pos;
    logic [DATA_W-1:0] data_q;
    logic              par_q, zero_q, noise_q, frm_q, perr_q;
    logic              line, vote, noisy, capture, in_win, bit_end, start_seen;
    logic              frame_done;
    logic [ERR_W-1:0]  wr_err;

    srx_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .pin(rx_pin), .loop_src(tx_loop),
        .loop_en(loop_en), .invert(invert_in), .line(line)
    );

    srx_vote u_vote (
        .clk(clk), .rst_n(rst_n), .line(line), .capture(capture),
        .vote(vote), .noisy(noisy)
    );

    // timing and control outputs
    always_comb begin
        last_idx   = ovs_last(ovs_sel);
        mid_idx    = ovs_mid(ovs_sel);
        wl_last    = IDX_W'(4) + IDX_W'(word_len);
        pos        = msb_first ? (wl_last - bidx_q) : bidx_q;
        start_seen = (state_q == ST_IDLE) && sample_tick && !line;
        in_win     = (tcnt_q == mid_idx - CNT_W'(1)) || (tcnt_q == mid_idx) ||
                     (tcnt_q == mid_idx + CNT_W'(1));
        capture    = (state_q == ST_IDLE) ? (start_seen && mid_idx == CNT_W'(1))
                                          : (sample_tick && in_win);
        bit_end    = sample_tick && (state_q != ST_IDLE) && (tcnt_q == last_idx);
        frame_done = bit_end && ((state_q == ST_STOP1 && !two_stop) ||
                                 (state_q == ST_STOP2));
        wr_err          = '0;
        wr_err[ERR_FRM] = frm_q | !vote;
        wr_err[ERR_PAR] = perr_q;
        wr_err[ERR_BRK] = zero_q & !vote;
        wr_err[ERR_NSE] = noise_q | noisy;
        rts        = rts_en & rx_empty;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_seen) state_d = ST_START;
            ST_START:  if (bit_end) state_d = vote ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_end && bidx_q == wl_last)
                           state_d = parity_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_end) state_d = ST_STOP1;
            ST_STOP1:  if (bit_end) state_d = two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            bidx_q  <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            zero_q  <= 1'b0;
            noise_q <= 1'b0;
            frm_q   <= 1'b0;
            perr_q  <= 1'b0;
        end else if (start_seen) begin
            tcnt_q  <= CNT_W'(1);
            bidx_q  <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            zero_q  <= 1'b1;
            noise_q <= 1'b0;
            frm_q   <= 1'b0;
            perr_q  <= 1'b0;
        end else if (sample_tick && state_q != ST_IDLE) begin
            tcnt_q <= bit_end ? '0 : tcnt_q + CNT_W'(1);
            if (bit_end) begin
                noise_q <= noise_q | noisy;
                zero_q  <= zero_q & !vote;
                case (state_q)
                    ST_DATA: begin
                        data_q[pos] <= vote;
                        par_q       <= par_q ^ vote;
                        bidx_q      <= bidx_q + IDX_W'(1);
                    end
                    ST_PARITY: perr_q <= par_q ^ vote ^ parity_odd;
                    ST_STOP1:  frm_q  <= !vote;
                    default:   ;
                endcase
            end
        end
    end

    srx_holding u_hold (
        .clk(clk), .rst_n(rst_n), .wr(frame_done), .wr_data(data_q),
        .wr_err(wr_err), .rd(rd_en), .empty(rx_empty), .data(rx_data),
        .err(rx_err), .top_err(rx_top_err)
    );
endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       rts,
    input logic       rx_empty,
    input logic [7:0] rx_data,
    input logic [4:0] rx_err,
    input logic [2:0] rx_top_err,
    input logic       frame_done
);
    // R1
    empty_until_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty && !frame_done |=> rx_empty);

    // R8
    held_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty && !rd_en |=> !rx_empty && $stable(rx_data));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty && rd_en && !frame_done |=> rx_empty);

    // R14
    framing_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err[4] |-> rx_top_err == 3'd1);

    // R14
    no_error_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err == 5'd0 |-> rx_top_err == 3'd0);

    // R13
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_empty) |-> !rts);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind serial_rx_unit serial_rx_unit_chk i_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rts(rts), .rx_empty(rx_empty),
    .rx_data(rx_data), .rx_err(rx_err), .rx_top_err(rx_top_err),
    .frame_done(frame_done)
);

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       sample_tick;
    logic [1:0] ovs_sel = 2'd0;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
    logic       msb_first = 1'b0, invert_in = 1'b0, loop_en = 1'b0;
    logic       rx_pin = 1'b1, tx_loop = 1'b1, rd_en = 1'b0, rts_en = 1'b1;
    logic       rx_empty, rts;
    logic [7:0] rx_data;
    logic [4:0] rx_err;
    logic [2:0] rx_top_err;
    int         n_chk = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tdiv <= tdiv + 2'd1;
    assign sample_tick = (tdiv == 2'd0);

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .ovs_sel(ovs_sel),
        .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd),
        .two_stop(two_stop), .msb_first(msb_first), .invert_in(invert_in),
        .loop_en(loop_en), .rx_pin(rx_pin), .tx_loop(tx_loop), .rd_en(rd_en),
        .rts_en(rts_en), .rx_empty(rx_empty), .rx_data(rx_data), .rx_err(rx_err),
        .rx_top_err(rx_top_err), .rts(rts)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (!sample_tick) @(posedge clk);
        #1;
    endtask

    task automatic set_line(input logic v);
        if (loop_en) begin
            tx_loop = v ^ invert_in;
            rx_pin  = 1'b0;
        end else begin
            rx_pin  = v ^ invert_in;
            tx_loop = 1'b1;
        end
    endtask

    task automatic send_bit(input logic v, input bit flip);
        int nt, mid;
        nt  = (ovs_sel == 2'd1) ? 8 : (ovs_sel == 2'd2) ? 3 : 16;
        mid = (nt == 16) ? 8 : (nt == 8) ? 4 : 1;
        for (int i = 0; i < nt; i++) begin
            set_line(v ^ (flip && i == mid));
            wait_tick();
        end
    endtask

    task automatic idle_ticks(input int n);
        set_line(1'b1);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    // bad_stop bit0: first stop low, bit1: second stop low
    task automatic send_frame(input logic [7:0] d, input logic [1:0] bad_stop,
                              input bit bad_par, input int noise_bit);
        int nb;
        logic p;
        nb = 5 + int'(word_len);
        p  = parity_odd ^ bad_par;
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) begin
            logic b;
            b = msb_first ? d[nb-1-i] : d[i];
            p = p ^ b;
            send_bit(b, i == noise_bit);
        end
        if (parity_en) send_bit(p, 1'b0);
        send_bit(!bad_stop[0], 1'b0);
        if (two_stop) send_bit(!bad_stop[1], 1'b0);
        idle_ticks(3);
    endtask

    task automatic read_word(input string req, input logic [7:0] ed,
                             input logic [4:0] ee, input logic [2:0] et);
        @(negedge clk);
        chk(req, "rx_empty", rx_empty, 0);
        chk(req, "rx_data", rx_data, ed);
        chk(req, "rx_err", rx_err, ee);
        chk(req, "rx_top_err", rx_top_err, et);
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
        @(negedge clk);
        chk(req, "rx_empty after read", rx_empty, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "rx_empty", rx_empty, 1);
        chk("R1", "rx_err", rx_err, 0);
        chk("R1", "rx_top_err", rx_top_err, 0);
        chk("R13", "rts idle", rts, 1);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 2'b00, 0, -1); read_word("R2", 8'hA5, 5'h00, 3'd0);
        send_frame(8'h3C, 2'b00, 0, -1); read_word("R2", 8'h3C, 5'h00, 3'd0);
    endtask

    task automatic t_wordlen();
        word_len = 2'd0; send_frame(8'hF5, 2'b00, 0, -1); read_word("R3", 8'h15, 5'h00, 3'd0);
        word_len = 2'd1; send_frame(8'hEB, 2'b00, 0, -1); read_word("R3", 8'h2B, 5'h00, 3'd0);
        word_len = 2'd2; send_frame(8'hC6, 2'b00, 0, -1); read_word("R3", 8'h46, 5'h00, 3'd0);
        word_len = 2'd3;
    endtask

    task automatic t_msb();
        msb_first = 1'b1;
        send_frame(8'hC1, 2'b00, 0, -1); read_word("R4", 8'hC1, 5'h00, 3'd0);
        word_len = 2'd0;
        send_frame(8'h13, 2'b00, 0, -1); read_word("R4", 8'h13, 5'h00, 3'd0);
        word_len = 2'd3; msb_first = 1'b0;
    endtask

    task automatic t_parity();
        parity_en = 1'b1;
        parity_odd = 1'b0;
        send_frame(8'h5A, 2'b00, 0, -1); read_word("R5", 8'h5A, 5'h00, 3'd0);
        send_frame(8'h5B, 2'b00, 1, -1); read_word("R5", 8'h5B, 5'h08, 3'd2);
        parity_odd = 1'b1;
        send_frame(8'h07, 2'b00, 0, -1); read_word("R5", 8'h07, 5'h00, 3'd0);
        send_frame(8'h06, 2'b00, 1, -1); read_word("R5", 8'h06, 5'h08, 3'd2);
        parity_en = 1'b0; parity_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h81, 2'b01, 0, -1); read_word("R6", 8'h81, 5'h10, 3'd1);
        two_stop = 1'b1;
        send_frame(8'h24, 2'b00, 0, -1); read_word("R6", 8'h24, 5'h00, 3'd0);
        send_frame(8'h24, 2'b10, 0, -1); read_word("R6", 8'h24, 5'h10, 3'd1);
        two_stop = 1'b0;
    endtask

    task automatic t_break();
        send_frame(8'h00, 2'b01, 0, -1); read_word("R7", 8'h00, 5'h14, 3'd1);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 2'b00, 0, -1);
        send_frame(8'h22, 2'b00, 0, -1);
        read_word("R8", 8'h11, 5'h02, 3'd4);
    endtask

    task automatic t_noise();
        send_frame(8'h01, 2'b00, 0, 0); read_word("R9", 8'h01, 5'h01, 3'd5);
        send_frame(8'h00, 2'b00, 0, 3); read_word("R9", 8'h00, 5'h01, 3'd5);
    endtask

    task automatic t_glitch();
        set_line(1'b0); wait_tick(); wait_tick();
        idle_ticks(40);
        @(negedge clk);
        chk("R10", "rx_empty after glitch", rx_empty, 1);
        send_frame(8'h99, 2'b00, 0, -1); read_word("R10", 8'h99, 5'h00, 3'd0);
    endtask

    task automatic t_ovs();
        ovs_sel = 2'd1; idle_ticks(2);
        send_frame(8'h6E, 2'b00, 0, -1); read_word("R11", 8'h6E, 5'h00, 3'd0);
        send_frame(8'h80, 2'b00, 0, 7); read_word("R11", 8'h80, 5'h01, 3'd5);
        ovs_sel = 2'd2; idle_ticks(2);
        send_frame(8'hB2, 2'b00, 0, -1); read_word("R11", 8'hB2, 5'h00, 3'd0);
        ovs_sel = 2'd0; idle_ticks(2);
    endtask

    task automatic t_loop_inv();
        loop_en = 1'b1; idle_ticks(4);
        send_frame(8'h4D, 2'b00, 0, -1); read_word("R12", 8'h4D, 5'h00, 3'd0);
        loop_en = 1'b0; idle_ticks(4);
        invert_in = 1'b1; idle_ticks(4);
        send_frame(8'hE7, 2'b00, 0, -1); read_word("R12", 8'hE7, 5'h00, 3'd0);
        invert_in = 1'b0; idle_ticks(4);
    endtask

    task automatic t_rts();
        send_frame(8'h42, 2'b00, 0, -1);
        @(negedge clk);
        chk("R13", "rts while held", rts, 0);
        read_word("R13", 8'h42, 5'h00, 3'd0);
        chk("R13", "rts after read", rts, 1);
        rts_en = 1'b0;
        @(negedge clk);
        chk("R13", "rts disabled", rts, 0);
        rts_en = 1'b1;
    endtask

    task automatic t_priority();
        parity_en = 1'b1;
        send_frame(8'h0F, 2'b01, 1, 2); read_word("R14", 8'h0F, 5'h19, 3'd1);
        send_frame(8'h0F, 2'b00, 1, 2); read_word("R14", 8'h0F, 5'h09, 3'd2);
        parity_en = 1'b0;
        send_frame(8'h30, 2'b00, 0, 1);
        send_frame(8'h55, 2'b00, 0, -1);
        read_word("R14", 8'h30, 5'h03, 3'd4);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        idle_ticks(4);
        t_basic();
        t_wordlen();
        t_msb();
        t_parity();
        t_framing();
        t_break();
        t_overrun();
        t_noise();
        t_glitch();
        t_ovs();
        t_loop_inv();
        t_rts();
        t_priority();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule